// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block is the processor-facing side of a serial controller. A host reaches it through a chip select, separate read and write strobes, a control/data select line and an 8-bit data bus. Control writes go through a fixed sequence. The first one after reset is the mode word. In synchronous mode, one or two sync characters come next. Every later control write goes to the command register. Data writes fill a transmit holding register. Data reads return the receive holding register. Status reads return a status byte assembled from the transmitter, the receiver and sticky error and sync flags.

The status byte the host sees is held steady while a status read is in progress. Any change that arrives during the read is applied once the read ends. Starting a status read clears the flag set by an external sync pulse. While chip select is inactive, the strobes change nothing at all.

Top module: `usart_host_if`

## Requirements
- R1: While cs_n is high, activity on rd_n, wr_n, cd and din leaves mode_o, cmd_o, tx_data_o, tx_full_o and the write sequence unchanged, and dout_o stays 0.
- R2: After reset, the first control write (cd=1) is stored in mode_o. Mode bits [1:0]=00 select synchronous mode, and any other value selects asynchronous mode.
- R3: In synchronous mode, the next control write is stored in sync1_o. If mode bit 7 is 0, one more control write is stored in sync2_o. After that, control writes go to cmd_o.
- R4: In asynchronous mode, the control write that follows the mode word goes straight to cmd_o.
- R5: A command with bit 6 set clears cmd_o to 0x00, and the next control write is again taken as the mode word.
- R6: A data write (cd=0) stores din in tx_data_o and sets tx_full_o on the next cycle. A pulse on tx_take_i clears tx_full_o. Status bit 0 (transmitter ready) equals the inverse of tx_full_o.
- R7: A pulse on rx_valid_i loads rx_data_i into the receive holding register and sets status bit 1. A data read returns that byte, and the start of the read clears status bit 1.
- R8: Status layout: bit 2 follows tx_empty_i, bits 3/4/5 are the sticky parity/overrun/framing error flags, bit 6 is sync detect, and bit 7 reads 0. After reset, status equals 0x01 plus bit 2 from tx_empty_i.
- R9: While a status read is held, dout_o does not change. A status event that arrives during the read shows up on the first status read after it.
- R10: With mode bit 6 set, status bit 6 is a flag. A pulse on ext_sync_i sets it, and the start of a status read clears it. With mode bit 6 clear, status bit 6 follows sync_det_i.
- R11: Once set, the error flags stay set until a command write with bit 4 set clears all three.
- R12: dout_o is 0 whenever no read is active (cs_n or rd_n high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | 8 | Host write data |
| dout_o | output | 8 | Host read data |
| mode_o | output | 8 | Mode word |
| sync1_o | output | 8 | First sync character |
| sync2_o | output | 8 | Second sync character |
| cmd_o | output | 8 | Command register |
| tx_data_o | output | 8 | Transmit holding register |
| tx_full_o | output | 1 | Transmit holding register occupied |
| tx_take_i | input | 1 | Transmitter took the held byte |
| tx_empty_i | input | 1 | Transmitter fully idle |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid pulse |
| pe_i | input | 1 | Parity error pulse |
| oe_i | input | 1 | Overrun error pulse |
| fe_i | input | 1 | Framing error pulse |
| sync_det_i | input | 1 | Internal sync detect level |
| ext_sync_i | input | 1 | External sync detect pulse |

## Verification
A write takes effect on the first clock edge at which the gated strobe is seen active. The bench drives every strobe on the falling edge and checks the register outputs on the next falling edge, one cycle later. A read returns the status register as it stood at the last edge before the read began, so the bench samples dout_o 1 ns after it asserts the read. Status events take one edge to reach the live state and one more to reach the visible copy once no read is active. The bench therefore always lets at least one full cycle pass between releasing a read and starting the next one. Side-event pulses last exactly one cycle, between falling edges.

// File: rtl/usart_if_pkg.sv
// Package: shared encodings for the host register interface.
// Assumes an 8-bit or wider register width so that all bit indices below exist.
package usart_if_pkg;
    typedef enum logic [1:0] {
        SEQ_MODE  = 2'd0,
        SEQ_SYNC1 = 2'd1,
        SEQ_SYNC2 = 2'd2,
        SEQ_CMD   = 2'd3
    } seq_e;

    localparam int ST_TXRDY   = 0;
    localparam int ST_RXRDY   = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_PERR    = 3;
    localparam int ST_OERR    = 4;
    localparam int ST_FERR    = 5;
    localparam int ST_SYNDET  = 6;

    localparam int MD_SINGLE  = 7;
    localparam int MD_EXTSYNC = 6;
    localparam int CMD_ERRCLR = 4;
    localparam int CMD_IRESET = 6;
endpackage

// File: rtl/usart_strobe.sv
// Module: gates the host strobes with chip select and turns them into
// single-cycle start pulses. Assumes strobes are synchronous to clk.
module usart_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic cd,
    output logic wr_ctl_go,
    output logic wr_dat_go,
    output logic rd_stat_act,
    output logic rd_stat_go,
    output logic rd_dat_go
);
    logic wr_act, rd_act, wr_q, rd_q;

    // Strobes only count while selected.
    always_comb begin
        wr_act = !cs_n && !wr_n;
        rd_act = !cs_n && !rd_n;
    end

    // Previous-cycle strobe state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    // Start pulses split by control/data select.
    always_comb begin
        wr_ctl_go   = wr_act && !wr_q && cd;
        wr_dat_go   = wr_act && !wr_q && !cd;
        rd_stat_act = rd_act && cd;
        rd_stat_go  = rd_act && !rd_q && cd;
        rd_dat_go   = rd_act && !rd_q && !cd;
    end
endmodule

// File: rtl/usart_ctrl_seq.sv
// Module: steers control writes to mode, sync characters or command.
// Assumes one write pulse per host write; internal reset restarts the sequence.
module usart_ctrl_seq
    import usart_if_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl_go,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] sync1_q,
    output logic [DW-1:0] sync2_q,
    output logic [DW-1:0] cmd_q,
    output logic          err_clr_o,
    output logic [1:0]    seq_o
);
    seq_e seq_q;
    logic sync_mode, single_sync;

    // Decode the synchronous flag and sync count from the incoming mode word.
    always_comb begin
        sync_mode   = (din[1:0] == 2'b00);
        single_sync = din[MD_SINGLE];
        seq_o       = seq_q;
        err_clr_o   = wr_ctl_go && (seq_q == SEQ_CMD) && din[CMD_ERRCLR];
    end

    // Write sequencing and register capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SEQ_MODE;
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            cmd_q   <= '0;
        end else if (wr_ctl_go) begin
            case (seq_q)
                SEQ_MODE: begin
                    mode_q <= din;
                    seq_q  <= sync_mode ? SEQ_SYNC1 : SEQ_CMD;
                end
                SEQ_SYNC1: begin
                    sync1_q <= din;
                    seq_q   <= mode_q[MD_SINGLE] ? SEQ_CMD : SEQ_SYNC2;
                end
                SEQ_SYNC2: begin
                    sync2_q <= din;
                    seq_q   <= SEQ_CMD;
                end
                default: begin
                    if (din[CMD_IRESET]) begin
                        cmd_q <= '0;
                        seq_q <= SEQ_MODE;
                    end else begin
                        cmd_q <= din;
                    end
                end
            endcase
        end
    end

    logic unused_ok;
    always_comb unused_ok = single_sync;
endmodule

// File: rtl/usart_data_buf.sv
// Module: transmit and receive holding registers with their ready flags.
// Assumes tx_take_i and rx_valid_i are single-cycle pulses; a set wins over a clear.
module usart_data_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dat_go,
    input  logic          rd_dat_go,
    input  logic [DW-1:0] din,
    input  logic          tx_take_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_valid_i,
    output logic [DW-1:0] tx_hold,
    output logic          tx_full,
    output logic [DW-1:0] rx_hold,
    output logic          rx_rdy
);
    // Transmit holding register and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
        end else if (wr_dat_go) begin
            tx_hold <= din;
            tx_full <= 1'b1;
        end else if (tx_take_i) begin
            tx_full <= 1'b0;
        end
    end

    // Receive holding register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_rdy  <= 1'b0;
        end else if (rx_valid_i) begin
            rx_hold <= rx_data_i;
            rx_rdy  <= 1'b1;
        end else if (rd_dat_go) begin
            rx_rdy  <= 1'b0;
        end
    end
endmodule

// File: rtl/usart_status.sv
// Module: sticky status flags, live status assembly and the host-visible copy
// that is frozen during a status read. Assumes event inputs are pulses.
module usart_status
    import usart_if_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic          stat_rd_go,
    input  logic          err_clr,
    input  logic          tx_rdy,
    input  logic          rx_rdy,
    input  logic          tx_empty_i,
    input  logic          ext_mode,
    input  logic          sync_det_i,
    input  logic          ext_sync_i,
    input  logic          pe_i,
    input  logic          oe_i,
    input  logic          fe_i,
    output logic [DW-1:0] stat_live,
    output logic [DW-1:0] stat_vis
);
    logic pe_q, oe_q, fe_q, ext_q;

    // Sticky error flags: clear first, then a same-cycle event sets again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q <= 1'b0;
            oe_q <= 1'b0;
            fe_q <= 1'b0;
        end else begin
            pe_q <= pe_i || (pe_q && !err_clr);
            oe_q <= oe_i || (oe_q && !err_clr);
            fe_q <= fe_i || (fe_q && !err_clr);
        end
    end

    // External sync flag, cleared when a status read starts.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_sync_i || (ext_q && !stat_rd_go);
    end

    // Live status byte.
    always_comb begin
        stat_live             = '0;
        stat_live[ST_TXRDY]   = tx_rdy;
        stat_live[ST_RXRDY]   = rx_rdy;
        stat_live[ST_TXEMPTY] = tx_empty_i;
        stat_live[ST_PERR]    = pe_q;
        stat_live[ST_OERR]    = oe_q;
        stat_live[ST_FERR]    = fe_q;
        stat_live[ST_SYNDET]  = ext_mode ? ext_q : sync_det_i;
    end

    // Visible copy, held while a status read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_vis           <= '0;
            stat_vis[ST_TXRDY] <= 1'b1;
        end else if (!freeze) begin
            stat_vis <= stat_live;
        end
    end
endmodule

// File: rtl/usart_host_if.sv
// Module: top of the host register interface; wires strobe gating, control
// sequencing, data buffers and status, and drives the read mux.
// Assumes all host signals are synchronous to clk.
module usart_host_if
    import usart_if_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout_o,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] sync1_o,
    output logic [DW-1:0] sync2_o,
    output logic [DW-1:0] cmd_o,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_full_o,
    input  logic          tx_take_i,
    input  logic          tx_empty_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_valid_i,
    input  logic          pe_i,
    input  logic          oe_i,
    input  logic          fe_i,
    input  logic          sync_det_i,
    input  logic          ext_sync_i
);
    logic wr_ctl_go, wr_dat_go, rd_stat_act, rd_stat_go, rd_dat_go;
    logic err_clr, rx_rdy;
    logic [1:0]    seq_st;
    logic [DW-1:0] rx_hold, stat_live_w, stat_vis;

    usart_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
        .wr_ctl_go(wr_ctl_go), .wr_dat_go(wr_dat_go), .rd_stat_act(rd_stat_act),
        .rd_stat_go(rd_stat_go), .rd_dat_go(rd_dat_go)
    );

    usart_ctrl_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_ctl_go(wr_ctl_go), .din(din),
        .mode_q(mode_o), .sync1_q(sync1_o), .sync2_q(sync2_o), .cmd_q(cmd_o),
        .err_clr_o(err_clr), .seq_o(seq_st)
    );

    usart_data_buf #(.DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_dat_go(wr_dat_go), .rd_dat_go(rd_dat_go),
        .din(din), .tx_take_i(tx_take_i), .rx_data_i(rx_data_i),
        .rx_valid_i(rx_valid_i), .tx_hold(tx_data_o), .tx_full(tx_full_o),
        .rx_hold(rx_hold), .rx_rdy(rx_rdy)
    );

    usart_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .freeze(rd_stat_act), .stat_rd_go(rd_stat_go),
        .err_clr(err_clr), .tx_rdy(!tx_full_o), .rx_rdy(rx_rdy),
        .tx_empty_i(tx_empty_i), .ext_mode(mode_o[MD_EXTSYNC]),
        .sync_det_i(sync_det_i), .ext_sync_i(ext_sync_i),
        .pe_i(pe_i), .oe_i(oe_i), .fe_i(fe_i),
        .stat_live(stat_live_w), .stat_vis(stat_vis)
    );

    // Host read mux: zero unless a selected read is active.
    always_comb begin
        if (!cs_n && !rd_n) dout_o = cd ? stat_vis : rx_hold;
        else                dout_o = '0;
    end
endmodule

// File: rtl/usart_host_if_chk.sv
// Module: property checker for usart_host_if, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module usart_host_if_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          cd,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout_o,
    input logic [DW-1:0] mode_o,
    input logic [DW-1:0] cmd_o,
    input logic          tx_full_o,
    input logic          pe_i,
    input logic          oe_i,
    input logic          fe_i,
    input logic [1:0]    seq_st,
    input logic [DW-1:0] stat_live_w
);
    logic wr_seen_q;
    logic wr_start, stat_rd;

    // Own copy of the write-start edge for antecedents.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen_q <= 1'b0;
        else        wr_seen_q <= !cs_n && !wr_n;
    end

    always_comb begin
        wr_start = !cs_n && !wr_n && !wr_seen_q;
        stat_rd  = !cs_n && !rd_n && cd;
    end

    p_cs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(mode_o) && $stable(cmd_o)));

    p_mode_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && cd && seq_st == 2'd0) |=> (mode_o == $past(din)));

    p_tx_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !cd) |=> tx_full_o);

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!stat_rd || $stable(dout_o)));

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && cd && seq_st == 2'd3 && din[4] && !pe_i && !oe_i && !fe_i)
        |=> (stat_live_w[5:3] == 3'b000));

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dout_o == '0));
endmodule

bind usart_host_if usart_host_if_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(din), .dout_o(dout_o), .mode_o(mode_o), .cmd_o(cmd_o),
    .tx_full_o(tx_full_o), .pe_i(pe_i), .oe_i(oe_i), .fe_i(fe_i),
    .seq_st(seq_st), .stat_live_w(stat_live_w)
);

// File: tb/usart_host_if_tb_top.sv
module usart_host_if_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout_o, mode_o, sync1_o, sync2_o, cmd_o, tx_data_o;
    logic tx_full_o;
    logic tx_take_i = 0, tx_empty_i = 1, rx_valid_i = 0;
    logic [7:0] rx_data_i = '0;
    logic pe_i = 0, oe_i = 0, fe_i = 0, sync_det_i = 0, ext_sync_i = 0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usart_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
        .din(din), .dout_o(dout_o), .mode_o(mode_o), .sync1_o(sync1_o),
        .sync2_o(sync2_o), .cmd_o(cmd_o), .tx_data_o(tx_data_o),
        .tx_full_o(tx_full_o), .tx_take_i(tx_take_i), .tx_empty_i(tx_empty_i),
        .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .pe_i(pe_i), .oe_i(oe_i),
        .fe_i(fe_i), .sync_det_i(sync_det_i), .ext_sync_i(ext_sync_i)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st(input bit txr, input bit rxr, input bit txe,
                                      input bit pe, input bit oe, input bit fe, input bit sd);
        return 8'(txr) + 8'(rxr) * 2 + 8'(txe) * 4 + 8'(pe) * 8 + 8'(oe) * 16
             + 8'(fe) * 32 + 8'(sd) * 64;
    endfunction

    task automatic wr(input bit c, input logic [7:0] v);
        @(negedge clk); cs_n = 0; wr_n = 0; cd = c; din = v;
        @(negedge clk); wr_n = 1; cs_n = 1;
    endtask

    task automatic rd(input bit c, output logic [7:0] v);
        @(negedge clk); cs_n = 0; rd_n = 0; cd = c;
        #1 v = dout_o;
        @(negedge clk); rd_n = 1; cs_n = 1;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v0, c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R8 reset state, R12 idle output
        chk("R12 idle", dout_o, 8'h00);
        chk("R2 reset mode", mode_o, 8'h00);
        rd(1, v); chk("R8 reset status", v, st(1,0,1,0,0,0,0));

        // R2 R3 R4 R5 sweep over every mode word
        for (int m = 0; m < 256; m++) begin
            wr(1, 8'(m)); chk("R2 mode", mode_o, 8'(m));
            if (m[1:0] == 2'b00) begin
                wr(1, 8'(m) ^ 8'hA5); chk("R3 sync1", sync1_o, 8'(m) ^ 8'hA5);
                if (!m[7]) begin
                    wr(1, 8'(m) ^ 8'h5A); chk("R3 sync2", sync2_o, 8'(m) ^ 8'h5A);
                end
            end
            c = (8'(m) ^ 8'h2C) & 8'hAF;
            wr(1, c); chk("R4 cmd", cmd_o, c);
            chk("R3 mode kept", mode_o, 8'(m));
            wr(1, 8'h40); chk("R5 ireset cmd", cmd_o, 8'h00);
        end

        // R1 chip-select gating: async mode, known command
        wr(1, 8'h4E); wr(1, 8'h05);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk); cs_n = 1; wr_n = 0; rd_n = 0; cd = k[0]; din = 8'(k);
            #1 chk("R1 dout", dout_o, 8'h00);
            @(negedge clk); wr_n = 1; rd_n = 1;
        end
        chk("R1 mode", mode_o, 8'h4E);
        chk("R1 cmd", cmd_o, 8'h05);
        chk("R1 tx", tx_data_o, 8'h00);
        chk("R1 txfull", 8'(tx_full_o), 8'h00);
        wr(1, 8'h27); chk("R1 seq unchanged", cmd_o, 8'h27);

        // R6 transmit path over all bytes
        for (int k = 0; k < 256; k++) begin
            wr(0, 8'(k));
            chk("R6 txdata", tx_data_o, 8'(k));
            chk("R6 txfull", 8'(tx_full_o), 8'h01);
            rd(1, v); chk("R6 status busy", v, st(0,0,1,0,0,0,0));
            pulse(tx_take_i);
            chk("R6 take", 8'(tx_full_o), 8'h00);
        end

        // R7 receive path
        for (int k = 0; k < 16; k++) begin
            rx_data_i = 8'(k * 17 + 3);
            pulse(rx_valid_i);
            rd(1, v); chk("R7 rxrdy set", v, st(1,1,1,0,0,0,0));
            rd(0, v); chk("R7 rxdata", v, 8'(k * 17 + 3));
            rd(1, v); chk("R7 rxrdy clr", v, st(1,0,1,0,0,0,0));
        end

        // R11 sticky errors and clear
        pulse(pe_i); rd(1, v); chk("R11 pe", v, st(1,0,1,1,0,0,0));
        pulse(oe_i); rd(1, v); chk("R11 oe", v, st(1,0,1,1,1,0,0));
        pulse(fe_i); rd(1, v); chk("R11 fe", v, st(1,0,1,1,1,1,0));
        wr(1, 8'h01); rd(1, v); chk("R11 sticky", v, st(1,0,1,1,1,1,0));
        wr(1, 8'h10); rd(1, v); chk("R11 clear", v, st(1,0,1,0,0,0,0));

        // R9 freeze during a held status read
        @(negedge clk); cs_n = 0; rd_n = 0; cd = 1;
        #1 v0 = dout_o;
        @(negedge clk); fe_i = 1; tx_empty_i = 0;
        @(negedge clk); fe_i = 0;
        repeat (3) @(negedge clk);
        chk("R9 frozen", dout_o, v0);
        rd_n = 1; cs_n = 1;
        rd(1, v); chk("R9 applied", v, st(1,0,0,0,0,1,0));
        tx_empty_i = 1;
        wr(1, 8'h10);

        // R10 internal sync detect in sync mode
        wr(1, 8'h40);               // internal reset
        wr(1, 8'h80); wr(1, 8'h16); wr(1, 8'h00);
        sync_det_i = 1;
        rd(1, v); chk("R10 internal", v, st(1,0,1,0,0,0,1));
        sync_det_i = 0;
        rd(1, v); chk("R10 internal low", v, st(1,0,1,0,0,0,0));
        // R10 external sync flag
        wr(1, 8'h40);
        wr(1, 8'h40); wr(1, 8'h16); wr(1, 8'h17); wr(1, 8'h00);
        chk("R10 mode", mode_o, 8'h40);
        sync_det_i = 1;
        rd(1, v); chk("R10 ext idle", v, st(1,0,1,0,0,0,0));
        pulse(ext_sync_i);
        rd(1, v); chk("R10 ext set", v, st(1,0,1,0,0,0,1));
        rd(1, v); chk("R10 ext cleared", v, st(1,0,1,0,0,0,0));
        sync_det_i = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule